// File: doc/BRIEF.md
# Double-Buffered Converter Input Register Front End

This block is the digital front end of a 16-bit digital-to-analog converter. A host with an 8-bit bus writes the converter code as two bytes, one into a low-byte holding register and one into a high-byte holding register. A separate transfer write then copies both bytes into the 16-bit output register in one step. The output register is the code that drives the converter. Because there are two stages, the analog output never shows a half-updated code.

When both byte enables are asserted together, the two holding registers become one 16-bit shift register. In that mode, bit 0 of the data bus is the serial input. Each write pulse shifts in one bit, most significant bit first, and a transfer write then moves the assembled word to the output.

A clear line zeroes both holding registers and loads 0000h into the output register, which is the bipolar-zero code in two's complement. A second output shows the same code with its MSB inverted, for straight-binary (unipolar) use downstream. All control lines are active low and are sampled on the system clock. The end of a write is found by comparing the write line with a registered copy of itself.

Top module: `dac_front_regs`

## Requirements
- R1: After reset, both `dacCode` and the holding registers are 0000h. All control inputs (`csN`, `wrN`, `loEnN`, `hiEnN`, `xferEnN`, `clrN`) are active low. While `csN` is high, no write changes any register.
- R2: A write with `csN` low, `loEnN` low and `hiEnN` high loads `dataIn` into the low holding byte, which is bits 7..0 of the word.
- R3: A write with `csN` low, `hiEnN` low and `loEnN` high loads `dataIn` into the high holding byte, which is bits 15..8 of the word.
- R4: A write with `xferEnN` low copies both holding bytes into `dacCode` together. Byte writes made without `xferEnN` leave `dacCode` unchanged.
- R5: A register whose enable is held low while `wrN` is held low tracks its input. A change on `dataIn` during such a write appears on `dacCode` on the following clock when `xferEnN` is also low.
- R6: With `loEnN` and `hiEnN` both low, each write shifts `dataIn[0]` into bit 0 of the 16-bit holding pair and moves the other bits up by one. After 16 pulses, the first bit sent sits in bit 15.
- R7: In serial mode, a shift happens only on the release of `wrN`, one bit per pulse, however long `wrN` stays low.
- R8: Serial shifting alone does not change `dacCode`. The word reaches `dacCode` only on a write with `xferEnN` low.
- R9: `clrN` low zeroes both holding bytes and sets `dacCode` to 0000h on the next clock. This takes priority over any write in the same cycle.
- R10: `dacCodeUni` always equals `dacCode` with bit 15 inverted. Bipolar zero (0000h) therefore reads 8000h on this output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| dataIn | input | 8 | Data byte; bit 0 is the serial input in serial mode |
| csN | input | 1 | Chip select, active low |
| wrN | input | 1 | Write strobe, active low |
| loEnN | input | 1 | Low holding byte enable, active low |
| hiEnN | input | 1 | High holding byte enable, active low |
| xferEnN | input | 1 | Transfer-to-output enable, active low |
| clrN | input | 1 | Clear, active low |
| dacCode | output | 16 | Output register, two's-complement code |
| dacCodeUni | output | 16 | Output register with MSB inverted |

## Verification
The bench loads bytes whose values differ in each half, such as 3Ch/A5h, so a swapped or missed byte lane shows up as a wrong value. It checks that byte writes without a transfer leave the output unchanged, and that a transfer with neither byte enabled shows the holding contents, which exposes the holding registers through the normal ports.

The serial stream uses an asymmetric word, so a reversed bit order or a dropped bit gives a different result. One long write pulse in serial mode separates edge-triggered shifting from level-triggered shifting. Clear asserted together with a loading write, and `csN` held high during a full write, confirm priority and gating.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 2 * BYTE_W;

  typedef struct packed {
    logic clearAll;
    logic loadLow;
    logic loadHigh;
    logic shiftIn;
    logic transfer;
  } ctrlStrobes_t;
endpackage

// File: rtl/dac_front_ctrl.sv
module dac_front_ctrl
  import dac_front_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         wrN,
  input  logic         loEnN,
  input  logic         hiEnN,
  input  logic         xferEnN,
  input  logic         clrN,
  output ctrlStrobes_t strobes
);
  logic wrPrev;
  logic selected;
  logic wrLow;
  logic wrRelease;
  logic serialMode;

  always_ff @(posedge clk) begin
    if (!rstN) wrPrev <= 1'b1;
    else       wrPrev <= wrN;
  end

  always_comb begin
    selected   = !csN;
    wrLow      = !wrN;
    wrRelease  = !wrPrev && wrN;
    serialMode = !loEnN && !hiEnN;

    strobes.clearAll = !clrN;
    strobes.loadLow  = selected && wrLow && !loEnN && hiEnN;
    strobes.loadHigh = selected && wrLow && !hiEnN && loEnN;
    strobes.shiftIn  = selected && wrRelease && serialMode;
    strobes.transfer = selected && wrLow && !xferEnN;
  end
endmodule

// File: rtl/dac_front_dp.sv
module dac_front_dp
  import dac_front_pkg::*;
#(
  parameter int BW = BYTE_W,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strobes,
  input  logic [BW-1:0] dataIn,
  output logic [CW-1:0] dacCode,
  output logic [CW-1:0] dacCodeUni
);
  logic [BW-1:0] lowByte;
  logic [BW-1:0] highByte;
  logic [BW-1:0] lowNext;
  logic [BW-1:0] highNext;
  logic [CW-1:0] dacNext;

  always_comb begin
    lowNext  = lowByte;
    highNext = highByte;
    if (strobes.loadLow)  lowNext  = dataIn;
    if (strobes.loadHigh) highNext = dataIn;
    if (strobes.shiftIn) {highNext, lowNext} = {highByte, lowByte, dataIn[0]};
    dacNext = strobes.transfer ? {highNext, lowNext} : dacCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll) begin
      lowByte  <= '0;
      highByte <= '0;
      dacCode  <= '0;
    end else begin
      lowByte  <= lowNext;
      highByte <= highNext;
      dacCode  <= dacNext;
    end
  end

  assign dacCodeUni = {~dacCode[CW-1], dacCode[CW-2:0]};
endmodule

// File: rtl/dac_front_regs.sv
module dac_front_regs
  import dac_front_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              csN,
  input  logic              wrN,
  input  logic              loEnN,
  input  logic              hiEnN,
  input  logic              xferEnN,
  input  logic              clrN,
  output logic [CODE_W-1:0] dacCode,
  output logic [CODE_W-1:0] dacCodeUni
);
  ctrlStrobes_t strobes;

  dac_front_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .loEnN(loEnN),
    .hiEnN(hiEnN), .xferEnN(xferEnN), .clrN(clrN), .strobes(strobes)
  );

  dac_front_dp #(.BW(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataIn(dataIn),
    .dacCode(dacCode), .dacCodeUni(dacCodeUni)
  );
endmodule

// File: rtl/dac_front_checker.sv
module dac_front_checker
  import dac_front_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [BYTE_W-1:0] dataIn,
  input logic              csN,
  input logic              wrN,
  input logic              loEnN,
  input logic              hiEnN,
  input logic              xferEnN,
  input logic              clrN,
  input logic [CODE_W-1:0] dacCode,
  input logic [CODE_W-1:0] dacCodeUni
);
  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |=> (dacCode == '0));

  assert_deselect_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (csN && clrN) |=> $stable(dacCode));

  assert_no_xfer_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (xferEnN && clrN) |=> $stable(dacCode));

  assert_low_track_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !wrN && !xferEnN && !loEnN && hiEnN && clrN)
      |=> (dacCode[BYTE_W-1:0] == $past(dataIn)));

  assert_high_track_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !wrN && !xferEnN && !hiEnN && loEnN && clrN)
      |=> (dacCode[CODE_W-1:BYTE_W] == $past(dataIn)));

  assert_uni_msb_R10: assert property (@(posedge clk) disable iff (!rstN)
    dacCodeUni[CODE_W-1] != dacCode[CODE_W-1]);
endmodule

bind dac_front_regs dac_front_checker i_dac_front_checker (.*);

// File: tb/test_dac_front_regs.sv
module test_dac_front_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  dataIn = '0;
  logic        csN = 1'b1, wrN = 1'b1, loEnN = 1'b1, hiEnN = 1'b1;
  logic        xferEnN = 1'b1, clrN = 1'b1;
  logic [15:0] dacCode, dacCodeUni;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  dac_front_regs i_dac_front_regs (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .csN(csN), .wrN(wrN),
    .loEnN(loEnN), .hiEnN(hiEnN), .xferEnN(xferEnN), .clrN(clrN),
    .dacCode(dacCode), .dacCodeUni(dacCodeUni)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    csN = 1'b1; wrN = 1'b1; loEnN = 1'b1; hiEnN = 1'b1; xferEnN = 1'b1; clrN = 1'b1;
  endtask

  // one write pulse: low for lowCycles clocks, then released with inputs held
  task automatic wrPulse(logic cs, logic lo, logic hi, logic xf, logic [7:0] d, int lowCycles);
    @(negedge clk);
    csN = cs; loEnN = lo; hiEnN = hi; xferEnN = xf; dataIn = d; wrN = 1'b0;
    repeat (lowCycles) @(negedge clk);
    wrN = 1'b1;
    @(negedge clk);
    idle();
    @(negedge clk);
  endtask

  task automatic showHolding(string req, logic [15:0] exp);
    wrPulse(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1);
    check(req, dacCode, exp);
  endtask

  task automatic tReset();
    check("R1 reset", dacCode, 16'h0000);
    check("R10 reset uni", dacCodeUni, 16'h8000);
  endtask

  task automatic tBytes();
    wrPulse(1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, 1);
    wrPulse(1'b0, 1'b1, 1'b0, 1'b1, 8'h3C, 1);
    check("R4 no transfer yet", dacCode, 16'h0000);
    showHolding("R2 R3 bytes", 16'h3CA5);
    check("R10 uni", dacCodeUni, 16'hBCA5);
    wrPulse(1'b1, 1'b0, 1'b1, 1'b0, 8'h11, 1);
    check("R1 cs high ignored", dacCode, 16'h3CA5);
    showHolding("R1 cs high holding", 16'h3CA5);
  endtask

  task automatic tTransparent();
    @(negedge clk);
    csN = 1'b0; loEnN = 1'b0; hiEnN = 1'b1; xferEnN = 1'b0; dataIn = 8'h12; wrN = 1'b0;
    @(negedge clk);
    check("R5 track first", dacCode, 16'h3C12);
    dataIn = 8'h9E;
    @(negedge clk);
    check("R5 track second", dacCode, 16'h3C9E);
    wrN = 1'b1;
    @(negedge clk);
    idle();
    @(negedge clk);
    check("R5 after release", dacCode, 16'h3C9E);
  endtask

  task automatic tSerial();
    logic [15:0] word = 16'hC3A1;
    for (int i = 15; i >= 0; i--)
      wrPulse(1'b0, 1'b0, 1'b0, 1'b1, {7'b1010101, word[i]}, 1);
    check("R8 serial no output change", dacCode, 16'h3C9E);
    showHolding("R6 serial word", 16'hC3A1);
    check("R10 uni serial", dacCodeUni, 16'h43A1);
    wrPulse(1'b0, 1'b0, 1'b0, 1'b1, 8'h01, 6);
    showHolding("R7 long pulse one shift", 16'h8743);
  endtask

  task automatic tClear();
    @(negedge clk);
    csN = 1'b0; loEnN = 1'b0; hiEnN = 1'b1; xferEnN = 1'b0; dataIn = 8'h77;
    wrN = 1'b0; clrN = 1'b0;
    @(negedge clk);
    check("R9 clear priority", dacCode, 16'h0000);
    check("R10 uni clear", dacCodeUni, 16'h8000);
    idle();
    @(negedge clk);
    showHolding("R9 holding cleared", 16'h0000);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBytes();
    tTransparent();
    tSerial();
    tClear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule